// File: doc/BRIEF.md
# Byte-Wide External Memory Bus Bridge

The bridge turns internal memory requests into timed cycles on a byte-wide external bus. That bus carries up to 23 address lines and four active-low chip selects. A request gives a 24-bit word address, a 16-bit write word and a read/write flag. The two top address bits choose the device. The next six bits choose a 64K-word bank inside that device. The low 16 bits are the offset. The requester holds the request until the bridge pulses a ready. With that pulse the bridge returns either read data or an error flag.

In wide mode each word becomes two back-to-back byte accesses at an even and an odd byte address. The chip select stays low through both. In narrow mode a single byte is moved, and the top bus address line stays low. The strobe pins follow one of two styles. The first has separate read and write strobes. The second has an enable pulse plus a read/write level, which lets display controllers with their own RAM sit on the same bus. A speed ratio n stretches every byte access to 2n clocks.

Top module: `xbus_bridge`

## Requirements
- R1: While `cfg_bus_en_i` is 0, a request gets an error response one cycle after acceptance. No chip select or strobe is asserted for it.
- R2: The device is selected by word address bits [23:22]. Device d drives `cs_no_o[d]` low, and at most one chip select is low at any time.
- R3: A request to device 0 with bank field (word address bits [21:16]) below 8 is answered with an error. No bus cycle takes place.
- R4: In narrow mode (`cfg_wide_i`=0) an access moves one byte at bus address {0, word address[21:0]}. Read data returns zero-extended in bits [7:0], a write drives `req_wdata_i[7:0]`, and the chip select is low for 2n cycles.
- R5: In wide mode an access moves byte {word address[21:0], 0} and then byte {word address[21:0], 1}. The even byte is bits [15:8] of the word and the odd byte is bits [7:0]. The chip select stays low, unchanged, for 4n cycles.
- R6: Every byte phase has n cycles with no strobe active, followed by n cycles with the strobe active. n is `cfg_ratio_i`, and a value of 0 counts as 1.
- R7: With `cfg_m68_i`=0, `rd_no_o` is low during the strobe cycles of a read and `wr_no_o` is low during those of a write. `e_o` stays 0.
- R8: With `cfg_m68_i`=1, `e_o` is high during strobe cycles. `rw_o` is 1 for a read and 0 for a write for as long as the chip select is low, and `rd_no_o` and `wr_no_o` stay high.
- R9: `data_oe_o` is high for every cycle of a write access while the chip select is low, and it is never high during a read.
- R10: A request is taken when the bridge is idle and `req_valid_i` is 1. `rsp_ready_o` is a single-cycle pulse. It comes 2n+1 cycles after the request is presented in narrow mode, 4n+1 in wide mode, and 1 for an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_bus_en_i | input | 1 | Bus enable |
| cfg_wide_i | input | 1 | 1: two bytes per word, 0: one byte |
| cfg_m68_i | input | 1 | 1: enable plus read/write level strobes, 0: separate strobes |
| cfg_ratio_i | input | 4 | Speed ratio n |
| req_valid_i | input | 1 | Request present, held until ready |
| req_write_i | input | 1 | 1: write, 0: read |
| req_addr_i | input | 24 | Word address: device, bank, offset |
| req_wdata_i | input | 16 | Write word |
| rsp_ready_o | output | 1 | Response pulse |
| rsp_err_o | output | 1 | Error flag with the response |
| rsp_rdata_o | output | 16 | Read word with the response |
| cs_no_o | output | 4 | Chip selects, active low |
| addr_o | output | 23 | Bus byte address |
| data_o | output | 8 | Bus write data |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | 8 | Bus read data |
| rd_no_o | output | 1 | Read strobe, active low |
| wr_no_o | output | 1 | Write strobe, active low |
| e_o | output | 1 | Enable pulse |
| rw_o | output | 1 | Read/write level |

## Verification
The assertions assume the four configuration inputs do not change while an access is in flight. Under that assumption, a cleared bus enable or a low top address line in narrow mode can be checked directly against the configuration pins. The bench changes configuration only between accesses, once the ready pulse has been seen. It also drops the request in the same cycle it sees ready, so every access is a separate transaction that starts from idle. The bench models the external device as a fixed function of the bus address, so read data follows from the address the bridge drives.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } xbus_state_e;
endpackage

// File: rtl/xbus_decode.sv
module xbus_decode #(
  parameter int WORD_AW      = 24,
  parameter int NCS          = 4,
  parameter int OFF_W        = 16,
  parameter int SHADOW_BANKS = 8
) (
  input  logic [WORD_AW-1:0] addr_i,
  output logic [NCS-1:0]     sel_o,
  output logic               shadow_o
);
  localparam int CS_W   = (NCS > 1) ? $clog2(NCS) : 1;
  localparam int DEV_AW = WORD_AW - CS_W;
  localparam int BANK_W = DEV_AW - OFF_W;

  logic [CS_W-1:0]   dev;
  logic [BANK_W-1:0] bank;

  assign dev  = addr_i[WORD_AW-1 -: CS_W];
  assign bank = addr_i[DEV_AW-1 -: BANK_W];

  for (genvar i = 0; i < NCS; i++) begin : g_sel
    assign sel_o[i] = (dev == CS_W'(i));
  end

  // low banks of device 0 belong to on-chip memory
  assign shadow_o = (dev == '0) && (bank < BANK_W'(SHADOW_BANKS));
endmodule

// File: rtl/xbus_timer.sv
module xbus_timer #(
  parameter int RATIO_W = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               run_i,
  input  logic               wide_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               half_o,
  output logic               byte_o,
  output logic               cap_o,
  output logic               last_o
);
  logic [RATIO_W-1:0] sub_q;
  logic               half_q, byte_q;
  logic [RATIO_W-1:0] n_m1;
  logic               end_half;

  assign n_m1     = (ratio_i == '0) ? '0 : ratio_i - RATIO_W'(1);
  assign end_half = (sub_q == n_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q  <= '0;
      half_q <= 1'b0;
      byte_q <= 1'b0;
    end else if (start_i) begin
      sub_q  <= '0;
      half_q <= 1'b0;
      byte_q <= 1'b0;
    end else if (run_i) begin
      if (end_half) begin
        sub_q  <= '0;
        half_q <= ~half_q;
        if (half_q) byte_q <= ~byte_q;
      end else begin
        sub_q <= sub_q + RATIO_W'(1);
      end
    end
  end

  assign half_o = half_q;
  assign byte_o = byte_q;
  assign cap_o  = run_i && end_half && half_q;
  assign last_o = cap_o && (byte_q || !wide_i);
endmodule

// File: rtl/xbus_strobe.sv
module xbus_strobe (
  input  logic active_i,
  input  logic write_i,
  input  logic half_i,
  input  logic m68_i,
  output logic rd_no,
  output logic wr_no,
  output logic e,
  output logic rw
);
  always_comb begin
    rd_no = 1'b1;
    wr_no = 1'b1;
    e     = 1'b0;
    rw    = 1'b1;
    if (active_i) begin
      if (m68_i) begin
        e  = half_i;
        rw = !write_i;
      end else begin
        rd_no = !(half_i && !write_i);
        wr_no = !(half_i && write_i);
      end
    end
  end
endmodule

// File: rtl/xbus_bridge.sv
module xbus_bridge
  import xbus_pkg::*;
#(
  parameter int WORD_AW      = 24,
  parameter int NCS          = 4,
  parameter int OFF_W        = 16,
  parameter int SHADOW_BANKS = 8,
  parameter int RATIO_W      = 4,
  parameter int BW           = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           cfg_bus_en_i,
  input  logic                           cfg_wide_i,
  input  logic                           cfg_m68_i,
  input  logic [RATIO_W-1:0]             cfg_ratio_i,
  input  logic                           req_valid_i,
  input  logic                           req_write_i,
  input  logic [WORD_AW-1:0]             req_addr_i,
  input  logic [2*BW-1:0]                req_wdata_i,
  output logic                           rsp_ready_o,
  output logic                           rsp_err_o,
  output logic [2*BW-1:0]                rsp_rdata_o,
  output logic [NCS-1:0]                 cs_no_o,
  output logic [WORD_AW-$clog2(NCS):0]   addr_o,
  output logic [BW-1:0]                  data_o,
  output logic                           data_oe_o,
  input  logic [BW-1:0]                  data_i,
  output logic                           rd_no_o,
  output logic                           wr_no_o,
  output logic                           e_o,
  output logic                           rw_o
);
  localparam int CS_W   = $clog2(NCS);
  localparam int DEV_AW = WORD_AW - CS_W;
  localparam int DW     = 2 * BW;

  xbus_state_e        st_q;
  logic [WORD_AW-1:0] addr_q;
  logic [DW-1:0]      wdata_q, rdata_q;
  logic [NCS-1:0]     sel_q;
  logic [RATIO_W-1:0] ratio_q;
  logic               write_q, wide_q, m68_q, err_q;

  logic [NCS-1:0]     sel;
  logic               shadow, accept, bad, busy;
  logic               half, byte_idx, cap, last;
  logic [DEV_AW-1:0]  dev_addr;

  xbus_decode #(
    .WORD_AW(WORD_AW), .NCS(NCS), .OFF_W(OFF_W), .SHADOW_BANKS(SHADOW_BANKS)
  ) u_dec (
    .addr_i  (req_addr_i),
    .sel_o   (sel),
    .shadow_o(shadow)
  );

  assign busy   = (st_q == ST_BUSY);
  assign accept = (st_q == ST_IDLE) && req_valid_i;
  assign bad    = !cfg_bus_en_i || shadow;

  xbus_timer #(.RATIO_W(RATIO_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(accept),
    .run_i  (busy),
    .wide_i (wide_q),
    .ratio_i(ratio_q),
    .half_o (half),
    .byte_o (byte_idx),
    .cap_o  (cap),
    .last_o (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      sel_q   <= '0;
      ratio_q <= '0;
      write_q <= 1'b0;
      wide_q  <= 1'b0;
      m68_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          addr_q  <= req_addr_i;
          wdata_q <= req_wdata_i;
          write_q <= req_write_i;
          wide_q  <= cfg_wide_i;
          m68_q   <= cfg_m68_i;
          ratio_q <= cfg_ratio_i;
          sel_q   <= sel;
          rdata_q <= '0;
          err_q   <= bad;
          st_q    <= bad ? ST_DONE : ST_BUSY;
        end
        ST_BUSY: begin
          if (cap) begin
            if (wide_q && !byte_idx) rdata_q[DW-1:BW] <= data_i;
            else                     rdata_q[BW-1:0]  <= data_i;
          end
          if (last) st_q <= ST_DONE;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign dev_addr = addr_q[DEV_AW-1:0];

  always_comb begin
    cs_no_o   = '1;
    addr_o    = '0;
    data_o    = '0;
    data_oe_o = 1'b0;
    if (busy) begin
      cs_no_o   = ~sel_q;
      addr_o    = wide_q ? {dev_addr, byte_idx} : {1'b0, dev_addr};
      data_oe_o = write_q;
      if (write_q) data_o = (wide_q && !byte_idx) ? wdata_q[DW-1:BW] : wdata_q[BW-1:0];
    end
  end

  xbus_strobe u_stb (
    .active_i(busy),
    .write_i (write_q),
    .half_i  (half),
    .m68_i   (m68_q),
    .rd_no   (rd_no_o),
    .wr_no   (wr_no_o),
    .e       (e_o),
    .rw      (rw_o)
  );

  assign rsp_ready_o = (st_q == ST_DONE);
  assign rsp_err_o   = rsp_ready_o && err_q;
  assign rsp_rdata_o = (rsp_ready_o && !err_q && !write_q) ? rdata_q : '0;
endmodule

// File: rtl/xbus_bridge_chk.sv
module xbus_bridge_chk #(
  parameter int WORD_AW = 24,
  parameter int NCS     = 4,
  parameter int RATIO_W = 4,
  parameter int BW      = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         cfg_bus_en_i,
  input logic                         cfg_wide_i,
  input logic                         cfg_m68_i,
  input logic                         rsp_ready_o,
  input logic                         rsp_err_o,
  input logic [NCS-1:0]               cs_no_o,
  input logic [WORD_AW-$clog2(NCS):0] addr_o,
  input logic                         data_oe_o,
  input logic                         rd_no_o,
  input logic                         wr_no_o,
  input logic                         e_o,
  input logic                         rw_o
);
  localparam int TOP = WORD_AW - $clog2(NCS);

  logic cs_act, stb_act;
  assign cs_act  = (cs_no_o != '1);
  assign stb_act = !rd_no_o || !wr_no_o || e_o;

  a_r1_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_bus_en_i |-> !cs_act && !stb_act);
  a_r1_off_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_ready_o && !cfg_bus_en_i) |-> rsp_err_o);
  a_r2_cs_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no_o));
  a_r4_top_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && !cfg_wide_i) |-> !addr_o[TOP]);
  a_r5_cs_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_no_o) != '1) |-> $stable(cs_no_o));
  a_r7_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!rd_no_o && !wr_no_o));
  a_r7_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_act |-> cs_act);
  a_r8_style_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_m68_i && cs_act) |-> rd_no_o && wr_no_o);
  a_r8_rw_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_act && $past(cs_no_o) != '1) |-> $stable(rw_o));
  a_r9_oe_not_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> rd_no_o && cs_act);
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ready_o |=> !rsp_ready_o);
endmodule

bind xbus_bridge xbus_bridge_chk #(
  .WORD_AW(WORD_AW), .NCS(NCS), .RATIO_W(RATIO_W), .BW(BW)
) u_chk (.*);

// File: tb/sim_xbus_bridge.sv
module sim_xbus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1, wide = 1'b0, m68 = 1'b0;
  logic [3:0]  ratio = 4'd3;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_ready_o, rsp_err_o;
  logic [15:0] rsp_rdata_o;
  logic [3:0]  cs_no_o;
  logic [22:0] addr_o;
  logic [7:0]  data_o, data_i;
  logic        data_oe_o, rd_no_o, wr_no_o, e_o, rw_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] dev_f(input logic [22:0] a);
    return a[7:0] ^ a[15:8] ^ {1'b0, a[22:16]} ^ 8'h3C;
  endfunction

  assign data_i = dev_f(addr_o);

  xbus_bridge u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_bus_en_i(en), .cfg_wide_i(wide), .cfg_m68_i(m68), .cfg_ratio_i(ratio),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata),
    .rsp_ready_o(rsp_ready_o), .rsp_err_o(rsp_err_o), .rsp_rdata_o(rsp_rdata_o),
    .cs_no_o(cs_no_o), .addr_o(addr_o), .data_o(data_o), .data_oe_o(data_oe_o),
    .data_i(data_i), .rd_no_o(rd_no_o), .wr_no_o(wr_no_o), .e_o(e_o), .rw_o(rw_o)
  );

  // bus monitor
  int          m_cs, m_stb, m_oe, m_rwlow, m_first, m_nacc, m_viol;
  logic [3:0]  m_cs_seen;
  logic [22:0] m_addr [2];
  logic [7:0]  m_dat  [2];
  bit          m_wr   [2];
  bit          stb_prev = 0;

  task automatic mon_clear();
    m_cs = 0; m_stb = 0; m_oe = 0; m_rwlow = 0; m_first = -1; m_nacc = 0;
    m_viol = 0; m_cs_seen = 4'hF;
  endtask

  always @(negedge clk) if (rst_n) begin
    bit cs_act, stb, wr;
    cs_act = (cs_no_o != 4'hF);
    stb = m68 ? e_o : (!rd_no_o || !wr_no_o);
    wr  = m68 ? (e_o && !rw_o) : !wr_no_o;
    if (cs_act) begin
      if (m_cs == 0) m_cs_seen = cs_no_o;
      m_cs++;
      if (data_oe_o) m_oe++;
      if (m68 && !rw_o) m_rwlow++;
    end
    if (stb) begin
      m_stb++;
      if (m_first < 0) m_first = m_cs - 1;
    end
    if (stb && !stb_prev && m_nacc < 2) begin
      m_addr[m_nacc] = addr_o; m_dat[m_nacc] = data_o; m_wr[m_nacc] = wr;
      m_nacc++;
    end
    if (stb && !cs_act) m_viol++;
    if (m68 && (!rd_no_o || !wr_no_o)) m_viol++;
    if (!m68 && e_o) m_viol++;
    stb_prev = stb;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  bit          g_err;
  logic [15:0] g_rdata;
  int          g_lat;

  task automatic run_req(input bit w, input logic [23:0] a, input logic [15:0] wd);
    bit got;
    @(negedge clk);
    mon_clear();
    req_write = w; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    g_lat = 0; got = 0;
    for (int i = 0; i < 200 && !got; i++) begin
      @(negedge clk);
      g_lat++;
      if (rsp_ready_o) begin
        got = 1; g_err = rsp_err_o; g_rdata = rsp_rdata_o; req_valid = 1'b0;
      end
    end
    if (!got) chk(0, "R10 ready timeout", 0, 1);
    @(negedge clk);
    chk(rsp_ready_o == 1'b0, "R10 ready single pulse", rsp_ready_o, 0);
  endtask

  function automatic logic [23:0] mk(input int d, input int b, input int o);
    return {2'(d), 6'(b), 16'(o)};
  endfunction

  task automatic t_reset();
    chk(cs_no_o == 4'hF, "R2 reset cs", cs_no_o, 4'hF);
    chk(rd_no_o && wr_no_o && !e_o, "R7 reset strobes", {rd_no_o, wr_no_o, e_o}, 3'b110);
    chk(!rsp_ready_o && !data_oe_o, "R10 reset ready/oe", {rsp_ready_o, data_oe_o}, 0);
  endtask

  task automatic t_read8();
    logic [23:0] a = mk(1, 5, 16'h1234);
    logic [22:0] ba = {1'b0, a[21:0]};
    en = 1; wide = 0; m68 = 0; ratio = 3;
    run_req(0, a, 16'h0);
    chk(!g_err, "R4 read8 no error", g_err, 0);
    chk(g_rdata == {8'h00, dev_f(ba)}, "R4 read8 data", g_rdata, {8'h00, dev_f(ba)});
    chk(m_cs_seen == 4'hD, "R2 read8 cs device 1", m_cs_seen, 4'hD);
    chk(m_cs == 6, "R4 read8 cs cycles", m_cs, 6);
    chk(m_stb == 3 && m_first == 3, "R6 read8 setup/strobe", {m_stb, m_first}, {32'd3, 32'd3});
    chk(m_nacc == 1 && m_addr[0] == ba && !m_wr[0], "R7 read8 one rd strobe", m_addr[0], ba);
    chk(m_oe == 0, "R9 read8 no drive", m_oe, 0);
    chk(g_lat == 7, "R10 read8 latency", g_lat, 7);
    chk(m_viol == 0, "R7 read8 pin rules", m_viol, 0);
  endtask

  task automatic t_write8();
    logic [23:0] a = mk(2, 6'h2A, 16'h00F0);
    logic [22:0] ba = {1'b0, a[21:0]};
    en = 1; wide = 0; m68 = 0; ratio = 2;
    run_req(1, a, 16'hA55A);
    chk(!g_err, "R4 write8 no error", g_err, 0);
    chk(m_cs_seen == 4'hB, "R2 write8 cs device 2", m_cs_seen, 4'hB);
    chk(m_nacc == 1 && m_wr[0] && m_addr[0] == ba, "R7 write8 wr strobe addr", m_addr[0], ba);
    chk(m_dat[0] == 8'h5A, "R4 write8 low byte", m_dat[0], 8'h5A);
    chk(m_oe == 4 && m_cs == 4, "R9 write8 drive span", m_oe, 4);
    chk(g_lat == 5, "R10 write8 latency", g_lat, 5);
  endtask

  task automatic t_read16();
    logic [23:0] a = mk(3, 6'h3F, 16'hFFFF);
    logic [22:0] b0 = {a[21:0], 1'b0};
    logic [22:0] b1 = {a[21:0], 1'b1};
    en = 1; wide = 1; m68 = 0; ratio = 2;
    run_req(0, a, 16'h0);
    chk(g_rdata == {dev_f(b0), dev_f(b1)}, "R5 read16 word order", g_rdata, {dev_f(b0), dev_f(b1)});
    chk(m_nacc == 2 && m_addr[0] == b0 && m_addr[1] == b1, "R5 read16 byte addresses", m_addr[1], b1);
    chk(m_cs == 8 && m_cs_seen == 4'h7, "R5 read16 cs span", m_cs, 8);
    chk(m_stb == 4 && m_first == 2, "R6 read16 strobes", m_stb, 4);
    chk(g_lat == 9, "R10 read16 latency", g_lat, 9);
  endtask

  task automatic t_write16();
    logic [23:0] a = mk(0, 8, 16'h0002);
    en = 1; wide = 1; m68 = 0; ratio = 1;
    run_req(1, a, 16'hBEEF);
    chk(!g_err, "R3 bank 8 reaches device 0", g_err, 0);
    chk(m_cs_seen == 4'hE, "R2 write16 cs device 0", m_cs_seen, 4'hE);
    chk(m_dat[0] == 8'hBE && m_addr[0] == {a[21:0], 1'b0}, "R5 write16 even high", m_dat[0], 8'hBE);
    chk(m_dat[1] == 8'hEF && m_addr[1] == {a[21:0], 1'b1}, "R5 write16 odd low", m_dat[1], 8'hEF);
    chk(m_oe == 4 && m_cs == 4, "R9 write16 drive span", m_oe, 4);
  endtask

  task automatic t_ratio0();
    en = 1; wide = 0; m68 = 0; ratio = 0;
    run_req(0, mk(1, 6'h10, 16'h0001), 16'h0);
    chk(m_cs == 2 && m_stb == 1 && m_first == 1, "R6 ratio 0 as 1", m_cs, 2);
    chk(g_lat == 3, "R10 ratio 0 latency", g_lat, 3);
  endtask

  task automatic t_shadow();
    en = 1; wide = 1; m68 = 0; ratio = 2;
    run_req(0, mk(0, 7, 16'h4444), 16'h0);
    chk(g_err, "R3 shadow bank error", g_err, 1);
    chk(m_cs == 0 && m_stb == 0, "R3 shadow no cycle", m_cs, 0);
    chk(g_lat == 1, "R10 error latency", g_lat, 1);
  endtask

  task automatic t_bus_off();
    en = 0; wide = 0; m68 = 0; ratio = 2;
    run_req(1, mk(2, 6'h20, 16'h0), 16'h1111);
    chk(g_err, "R1 disabled error", g_err, 1);
    chk(m_cs == 0 && m_stb == 0 && m_oe == 0, "R1 disabled quiet", m_cs + m_stb, 0);
    en = 1;
  endtask

  task automatic t_6800();
    logic [23:0] a = mk(1, 6'h11, 16'h8000);
    en = 1; wide = 1; m68 = 1; ratio = 2;
    run_req(0, a, 16'h0);
    chk(m_stb == 4 && m_nacc == 2, "R8 read e pulses", m_stb, 4);
    chk(m_rwlow == 0 && m_viol == 0, "R8 read rw high", m_rwlow, 0);
    chk(g_rdata == {dev_f({a[21:0], 1'b0}), dev_f({a[21:0], 1'b1})}, "R8 read data", g_rdata, 0);
    run_req(1, a, 16'h1357);
    chk(m_rwlow == 8 && m_cs == 8, "R8 write rw low span", m_rwlow, 8);
    chk(m_dat[0] == 8'h13 && m_dat[1] == 8'h57 && m_wr[1], "R8 write bytes", {m_dat[0], m_dat[1]}, 16'h1357);
    chk(m_viol == 0, "R8 no separate strobes", m_viol, 0);
    m68 = 0;
  endtask

  task automatic t_cs_sweep();
    en = 1; wide = 0; m68 = 0; ratio = 1;
    for (int d = 0; d < 4; d++) begin
      run_req(0, mk(d, 6'h30, 16'h0055), 16'h0);
      chk(m_cs_seen == ~(4'b0001 << d), "R2 cs sweep", m_cs_seen, ~(4'b0001 << d));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_read8();
    t_write8();
    t_read16();
    t_write16();
    t_ratio0();
    t_shadow();
    t_bus_off();
    t_6800();
    t_cs_sweep();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule